// File: doc/BRIEF.md
# Memory access watchpoint matcher

This block watches the stream of memory-operand accesses issued by a 16-bit processor. It compares each access with a table of watch entries and reports which entries fired. For every access it forms an event word from the access kind (read or write) and from the flag that marks the operand as a memory reference. Accesses to registers or literals are not memory references and raise no event. The event word is then compared in parallel against every stored entry.

Each entry holds two masks. The first is a required mask: all of its bits must be present in the event. The second is an alternative mask: at least one of its bits must also be present. A host appends entries through a simple registration port, one per cycle, in order. Entry k always owns bit k of the hit vector. When a registration arrives and all slots are taken, the table refuses it and raises an error pulse.

When at least one entry matches, the block registers the hit vector, the 16-bit effective address and the event word, and raises a one-cycle strobe. Accesses can arrive on consecutive cycles. Each one produces its own result one cycle later, in the order the accesses arrived. A processor therefore presents the source read first, then the destination read, then the destination write, and the results come back in that same order.

Top module: `wp_watch_matcher`

## Requirements
- R1: The event word has bit 1 set for a read (`acc_write`=0), bit 2 set for a write (`acc_write`=1) and bit 3 set for a memory operand; all other bits are zero. A hit reports it on `hit_event`, so a read gives 0x0A and a write gives 0x0C.
- R2: An entry matches an event only when (required AND event) equals required and (alternative AND event) is nonzero.
- R3: An access with `acc_mem`=0 raises no event: no strobe follows, whatever the table holds.
- R4: An entry whose alternative mask is zero never matches.
- R5: The n-th accepted registration (counting from 0) owns bit n of `hit_vec`.
- R6: Every matching entry fires for the same event, so several bits of `hit_vec` can be set together.
- R7: The table holds NENT entries. A registration while it is full is refused: `reg_err` is high for exactly the cycle after the attempt, and the table is left unchanged. An accepted registration leaves `reg_err` low.
- R8: `hit_valid`, `hit_vec`, `hit_addr` and `hit_event` are updated on the clock edge that samples the access. When no entry matches, `hit_valid` stays low and `hit_vec` is zero.
- R9: Accesses on back-to-back cycles each produce their own result, in arrival order.
- R10: After reset the table is empty and all outputs are zero.
- R11: A registration is visible to matching from the cycle after it is accepted. An access in the same cycle does not see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_valid | input | 1 | Append one watch entry |
| reg_all_mask | input | FLAGW | Required mask of the new entry |
| reg_any_mask | input | FLAGW | Alternative mask of the new entry |
| reg_err | output | 1 | Registration refused because the table is full |
| acc_valid | input | 1 | An operand access is presented |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_mem | input | 1 | Operand is a memory reference |
| acc_addr | input | AW | Effective address of the access |
| hit_valid | output | 1 | Strobe: at least one entry matched |
| hit_vec | output | NENT | One bit per matching entry |
| hit_addr | output | AW | Address of the matched access |
| hit_event | output | FLAGW | Event word of the matched access |

## Verification
The hardest condition to reach from the ports is a full table. Getting there takes a long series of registrations. After that, the refused registration must be shown to leave the table unchanged, and the only way to see that is through a later match. The bench fills every slot with a write-only watch. It then attempts one more read watch and checks the error pulse. Finally it issues a read and a write: the read hit vector must show that no read watch was added, and the write hit vector must show that every filled slot answers. A second hard case is a registration and an access in the same cycle. The bench drives both at once, then repeats the access alone on the next cycle.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int FLAG_RD  = 1;
  localparam int FLAG_WR  = 2;
  localparam int FLAG_MEM = 3;

  function automatic logic [7:0] make_event(input logic is_write, input logic is_mem);
    logic [7:0] ev;
    ev = '0;
    ev[FLAG_RD]  = ~is_write;
    ev[FLAG_WR]  = is_write;
    ev[FLAG_MEM] = is_mem;
    return ev;
  endfunction
endpackage

// File: rtl/wp_table.sv
module wp_table #(
  parameter int NENT  = 32,
  parameter int FLAGW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_valid,
  input  logic [FLAGW-1:0]           all_in,
  input  logic [FLAGW-1:0]           any_in,
  output logic [NENT-1:0][FLAGW-1:0] all_tab,
  output logic [NENT-1:0][FLAGW-1:0] any_tab,
  output logic [NENT-1:0]            used,
  output logic                       reg_err
);
  localparam int CNTW = $clog2(NENT + 1);

  logic [CNTW-1:0] cnt_q, cnt_nxt;
  logic            err_nxt, full, wr_en;

  assign full  = (cnt_q == CNTW'(NENT));
  assign wr_en = reg_valid && !full;

  always_comb begin
    cnt_nxt = cnt_q;
    err_nxt = 1'b0;
    if (reg_valid) begin
      if (full) err_nxt = 1'b1;
      else      cnt_nxt = cnt_q + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      reg_err <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      reg_err <= err_nxt;
    end
  end

  for (genvar i = 0; i < NENT; i++) begin : g_slot
    assign used[i] = (cnt_q > CNTW'(i));
    always_ff @(posedge clk) begin
      if (wr_en && (cnt_q == CNTW'(i))) begin
        all_tab[i] <= all_in;
        any_tab[i] <= any_in;
      end
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(NENT));
  p_err_only_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> $past(reg_valid && full));
  p_append_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && !full) |=> (cnt_q == $past(cnt_q) + CNTW'(1)));
  p_hold_when_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(used));
endmodule

// File: rtl/wp_match.sv
module wp_match #(
  parameter int NENT  = 32,
  parameter int FLAGW = 8
) (
  input  logic                       ev_ok,
  input  logic [FLAGW-1:0]           ev,
  input  logic [NENT-1:0][FLAGW-1:0] all_tab,
  input  logic [NENT-1:0][FLAGW-1:0] any_tab,
  input  logic [NENT-1:0]            used,
  output logic [NENT-1:0]            hit
);
  for (genvar i = 0; i < NENT; i++) begin : g_cmp
    logic all_ok, any_ok;
    assign all_ok = ((all_tab[i] & ev) == all_tab[i]);
    assign any_ok = |(any_tab[i] & ev);
    assign hit[i] = ev_ok && used[i] && all_ok && any_ok;
  end
endmodule

// File: rtl/wp_hit_reg.sv
module wp_hit_reg #(
  parameter int NENT  = 32,
  parameter int FLAGW = 8,
  parameter int AW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_ok,
  input  logic [NENT-1:0]  hit_in,
  input  logic [AW-1:0]    addr_in,
  input  logic [FLAGW-1:0] ev_in,
  output logic             hit_valid,
  output logic [NENT-1:0]  hit_vec,
  output logic [AW-1:0]    hit_addr,
  output logic [FLAGW-1:0] hit_event
);
  logic             v_nxt;
  logic [NENT-1:0]  vec_nxt;
  logic [AW-1:0]    addr_nxt;
  logic [FLAGW-1:0] ev_nxt;

  always_comb begin
    v_nxt    = ev_ok && (|hit_in);
    vec_nxt  = '0;
    addr_nxt = '0;
    ev_nxt   = '0;
    if (v_nxt) begin
      vec_nxt  = hit_in;
      addr_nxt = addr_in;
      ev_nxt   = ev_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_vec   <= '0;
      hit_addr  <= '0;
      hit_event <= '0;
    end else begin
      hit_valid <= v_nxt;
      hit_vec   <= vec_nxt;
      hit_addr  <= addr_nxt;
      hit_event <= ev_nxt;
    end
  end

  p_strobe_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> $past(ev_ok));
  p_vec_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (hit_vec != '0));
  p_quiet_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_valid |-> (hit_vec == '0));
endmodule

// File: rtl/wp_watch_matcher.sv
module wp_watch_matcher #(
  parameter int NENT  = 32,
  parameter int FLAGW = 8,
  parameter int AW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_valid,
  input  logic [FLAGW-1:0] reg_all_mask,
  input  logic [FLAGW-1:0] reg_any_mask,
  output logic             reg_err,
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_mem,
  input  logic [AW-1:0]    acc_addr,
  output logic             hit_valid,
  output logic [NENT-1:0]  hit_vec,
  output logic [AW-1:0]    hit_addr,
  output logic [FLAGW-1:0] hit_event
);
  import wp_pkg::*;

  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic [NENT-1:0][FLAGW-1:0] all_tab, any_tab;
  logic [NENT-1:0]            used, hit;
  logic                       ev_ok;
  logic [7:0]                 ev8;
  logic [FLAGW-1:0]           ev;

  assign ev_ok = acc_valid && acc_mem;
  assign ev8   = make_event(acc_write, acc_mem);
  assign ev    = FLAGW'(ev8);

  wp_table #(.NENT(NENT), .FLAGW(FLAGW)) u_table (
    .clk(clk), .rst_n(rst_int_n), .reg_valid(reg_valid),
    .all_in(reg_all_mask), .any_in(reg_any_mask),
    .all_tab(all_tab), .any_tab(any_tab), .used(used), .reg_err(reg_err)
  );

  wp_match #(.NENT(NENT), .FLAGW(FLAGW)) u_match (
    .ev_ok(ev_ok), .ev(ev), .all_tab(all_tab), .any_tab(any_tab),
    .used(used), .hit(hit)
  );

  wp_hit_reg #(.NENT(NENT), .FLAGW(FLAGW), .AW(AW)) u_out (
    .clk(clk), .rst_n(rst_int_n), .ev_ok(ev_ok), .hit_in(hit),
    .addr_in(acc_addr), .ev_in(ev), .hit_valid(hit_valid),
    .hit_vec(hit_vec), .hit_addr(hit_addr), .hit_event(hit_event)
  );

  p_event_mem_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit_valid |-> hit_event[FLAG_MEM]);
  p_event_kind_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit_valid |-> $onehot(hit_event[FLAG_WR:FLAG_RD]));
  p_addr_follows_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    hit_valid |-> (hit_addr == $past(acc_addr)));
endmodule

// File: tb/tb_wp_watch_matcher.sv
module tb_wp_watch_matcher;
  localparam int NENT = 32, FLAGW = 8, AW = 16;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic             reg_valid = 1'b0;
  logic [FLAGW-1:0] reg_all_mask = '0, reg_any_mask = '0;
  logic             reg_err;
  logic             acc_valid = 1'b0, acc_write = 1'b0, acc_mem = 1'b0;
  logic [AW-1:0]    acc_addr = '0;
  logic             hit_valid;
  logic [NENT-1:0]  hit_vec;
  logic [AW-1:0]    hit_addr;
  logic [FLAGW-1:0] hit_event;

  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  wp_watch_matcher #(.NENT(NENT), .FLAGW(FLAGW), .AW(AW)) dut (.*);

  // vector: [49] write, [48] mem, [47:32] addr, [31:0] expected hit vector
  localparam logic [49:0] VEC [6] = '{
    {1'b0, 1'b1, 16'h1234, 32'h0000_0023},
    {1'b1, 1'b1, 16'hBEEF, 32'h0000_0025},
    {1'b0, 1'b0, 16'h0001, 32'h0000_0000},
    {1'b1, 1'b0, 16'hFFFF, 32'h0000_0000},
    {1'b0, 1'b1, 16'h0000, 32'h0000_0023},
    {1'b1, 1'b1, 16'hFFFF, 32'h0000_0025}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic add_entry(input logic [7:0] am, input logic [7:0] om);
    reg_valid = 1'b1; reg_all_mask = am; reg_any_mask = om;
    @(posedge clk); #1;
    reg_valid = 1'b0;
  endtask

  task automatic access(input logic w, input logic m, input logic [15:0] a);
    acc_valid = 1'b1; acc_write = w; acc_mem = m; acc_addr = a;
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 hit_valid", 32'(hit_valid), 0);
    chk("R10 hit_vec", hit_vec, 0);
    chk("R10 reg_err", 32'(reg_err), 0);
    access(1'b0, 1'b1, 16'h0042);
    chk("R10 empty table no hit", 32'(hit_valid), 0);

    // R11 registration and access in the same cycle
    reg_valid = 1'b1; reg_all_mask = 8'h00; reg_any_mask = 8'h08;
    acc_valid = 1'b1; acc_write = 1'b0; acc_mem = 1'b1; acc_addr = 16'h0100;
    @(posedge clk); #1;
    reg_valid = 1'b0; acc_valid = 1'b0;
    chk("R11 same cycle unseen", 32'(hit_valid), 0);
    chk("R7 accepted no err", 32'(reg_err), 0);
    access(1'b0, 1'b1, 16'h0100);
    chk("R11 next cycle seen", hit_vec, 32'h1);

    // entries 1..5
    add_entry(8'h0A, 8'h08);  // memory reads
    add_entry(8'h0C, 8'h0C);  // memory writes
    add_entry(8'h00, 8'h00);  // R4 zero alternative mask
    add_entry(8'h02, 8'h04);  // needs read and write: never
    add_entry(8'h00, 8'h06);  // any read or write

    // R1 R2 R3 R6 R8 R9 vectors, driven back to back
    for (int i = 0; i < 6; i++) begin
      logic [49:0] v;
      v = VEC[i];
      acc_valid = 1'b1; acc_write = v[49]; acc_mem = v[48]; acc_addr = v[47:32];
      @(posedge clk); #1;
      chk($sformatf("R9 R8 vec%0d valid", i), 32'(hit_valid), 32'(v[31:0] != 0));
      chk($sformatf("R2 R6 vec%0d hits", i), hit_vec, v[31:0]);
      if (v[31:0] != 0) begin
        chk($sformatf("R8 vec%0d addr", i), 32'(hit_addr), 32'(v[47:32]));
        chk($sformatf("R1 vec%0d event", i), 32'(hit_event), v[49] ? 32'h0C : 32'h0A);
      end else begin
        chk($sformatf("R3 vec%0d silent", i), 32'(hit_addr), 0);
      end
    end
    acc_valid = 1'b0;
    @(posedge clk); #1;
    chk("R8 strobe one cycle", 32'(hit_valid), 0);

    // R4: with only the zero-mask entry possible, nothing else changes bit 3
    access(1'b1, 1'b1, 16'h7777);
    chk("R4 zero mask never", 32'(hit_vec[3]), 0);

    // R5 fill slots 6..31 with write watches
    for (int k = 6; k < NENT; k++) add_entry(8'h00, 8'h04);
    access(1'b1, 1'b1, 16'h2222);
    chk("R5 R6 full write hits", hit_vec, 32'hFFFF_FFE5);

    // R7 refused registration
    add_entry(8'h00, 8'h02);
    chk("R7 reg_err pulse", 32'(reg_err), 1);
    @(posedge clk); #1;
    chk("R7 reg_err one cycle", 32'(reg_err), 0);
    access(1'b0, 1'b1, 16'h3333);
    chk("R7 table unchanged", hit_vec, 32'h0000_0023);
    chk("R1 read event", 32'(hit_event), 32'h0A);

    finish_run();
  end
endmodule